// File: doc/BRIEF.md
# Dual-Halfword Vector Shift Unit

This unit shifts the two 16-bit halves of a 32-bit word by one common 5-bit signed amount and returns both results packed back into their original positions. Two operations are offered: a left shift, which may clamp each half instead of wrapping, and an arithmetic right shift. The amount is read as a two's-complement number from -16 to +15. An amount outside 0..15 reverses the direction of the shift instead of being clamped.

A left shift with a negative amount becomes an arithmetic right shift by the magnitude of that amount. An arithmetic right shift whose amount has bit 4 set becomes a plain left shift by sixteen minus the low four amount bits. That reversed shift never saturates.

Each accepted operation produces a result word and an overflow indication. The overflow is ORed across both halves and also gathered into a sticky flag, which only reset clears. All outputs are registered, so a result appears one clock after its operands.

Top module: `vsh_dual_shift`

## Requirements
- R1: When `in_valid` is sampled high, `out_valid` is high in the following cycle with the new `result`, `ovf` and `sticky`. When `in_valid` is low, `out_valid` drops in the next cycle and `result` and `ovf` keep their values.
- R2: Bits [15:0] and bits [31:16] of `src` are each treated as a separate signed 16-bit lane, shifted by the same amount. Each result is written back to the same bit positions, and one lane's value never affects the other lane's result.
- R3: With `op`=0 (left) and `amt[4]`=0, each lane is shifted left by `amt` (0..15) with zeros entering at bit 0. When `sat`=0, any bits shifted out are discarded and the lane wraps. An amount of 0 passes both lanes through unchanged for either operation.
- R4: With `op`=0, `amt[4]`=0 and `sat`=1, a lane that would lose significant bits is replaced by 0x7FFF when its input bit 15 is 0, and by 0x8000 when its input bit 15 is 1.
- R5: With `op`=0 and `amt[4]`=0, `ovf` is 1 when the signed product lane×2^amt of either lane lies outside -32768..32767. This holds whatever the value of `sat`.
- R6: With `op`=0 and `amt[4]`=1, the amount is read as -16..-1, and each lane is arithmetically shifted right by its magnitude, 1..16. A shift of 16 fills the lane with its sign bit, and `ovf` is 0.
- R7: With `op`=1 (arithmetic right) and `amt[4]`=0, each lane is shifted right by `amt` with copies of bit 15 entering at the top, and `ovf` is 0.
- R8: With `op`=1 and `amt[4]`=1, each lane is shifted left by 16−`amt[3:0]` (1..16) with zero fill, no saturation and `ovf`=0. `amt`=16 therefore gives 0x0000.
- R9: `sticky` goes high in the cycle `ovf` goes high and stays high until reset.
- R10: During and right after reset, `out_valid`, `result`, `ovf` and `sticky` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands are presented this cycle |
| src | input | 32 | Two packed signed 16-bit lanes |
| amt | input | 5 | Signed shift amount, -16..15 |
| op | input | 1 | 0 = left shift, 1 = arithmetic right shift |
| sat | input | 1 | Clamp instead of wrap on left shift |
| out_valid | output | 1 | Result registers were loaded last cycle |
| result | output | 32 | Packed shifted lanes |
| ovf | output | 1 | Either lane overflowed in the last operation |
| sticky | output | 1 | OR of every overflow since reset |

## Verification
Every output comes from one register stage, so each result, overflow bit and sticky update is due one rising edge after the cycle in which `in_valid` was high. The bench drives operands on a falling edge and drops `in_valid` on the next falling edge. At that same falling edge, after exactly one rising edge, it compares all four outputs with its own model. Hold checks sample one further cycle later, after an input change made with `in_valid` low, to confirm that nothing moved.

// File: rtl/vsh_pkg.sv
package vsh_pkg;
    localparam int LANE_W  = 16;
    localparam int SHAMT_W = 5;
    localparam int LANES   = 2;

    typedef enum logic {
        OP_SHL = 1'b0,
        OP_ASR = 1'b1
    } vsh_op_e;
endpackage

// File: rtl/vsh_lane.sv
module vsh_lane
    import vsh_pkg::*;
#(
    parameter int LANE_W  = vsh_pkg::LANE_W,
    parameter int SHAMT_W = vsh_pkg::SHAMT_W
) (
    input  logic [LANE_W-1:0]  x,
    input  logic [SHAMT_W-1:0] amt,
    input  logic               op,
    input  logic               sat,
    output logic [LANE_W-1:0]  y,
    output logic               ovf
);
    localparam int CNT_W = SHAMT_W + 1;
    localparam int EXT_W = 2 * LANE_W;

    logic               neg;
    logic [CNT_W-1:0]   low_n;
    logic [CNT_W-1:0]   mag_n;
    logic [CNT_W-1:0]   rev_n;
    logic [LANE_W-1:0]  shl_val;
    logic [LANE_W-1:0]  back_val;
    logic               loss;
    logic [LANE_W-1:0]  clamp_val;

    function automatic logic [LANE_W-1:0] asr_f(input logic [LANE_W-1:0] v,
                                                 input logic [CNT_W-1:0] n);
        if (int'(n) >= LANE_W)
            return {LANE_W{v[LANE_W-1]}};
        else
            return LANE_W'($signed(v) >>> n);
    endfunction

    function automatic logic [LANE_W-1:0] shl_f(input logic [LANE_W-1:0] v,
                                                 input logic [CNT_W-1:0] n);
        logic [EXT_W-1:0] wide;
        wide = {{(EXT_W-LANE_W){1'b0}}, v} << n;
        return wide[LANE_W-1:0];
    endfunction

    always_comb begin
        neg       = amt[SHAMT_W-1];
        low_n     = {2'b00, amt[SHAMT_W-2:0]};
        mag_n     = CNT_W'(-$signed({amt[SHAMT_W-1], amt}));
        rev_n     = CNT_W'(LANE_W) - low_n;
        shl_val   = shl_f(x, low_n);
        back_val  = asr_f(shl_val, low_n);
        loss      = (back_val != x);
        clamp_val = x[LANE_W-1] ? {1'b1, {(LANE_W-1){1'b0}}}
                                : {1'b0, {(LANE_W-1){1'b1}}};
        y   = '0;
        ovf = 1'b0;
        unique case ({op, neg})
            {OP_SHL, 1'b0}: begin
                y   = (loss && sat) ? clamp_val : shl_val;
                ovf = loss;
            end
            {OP_SHL, 1'b1}: y = asr_f(x, mag_n);
            {OP_ASR, 1'b0}: y = asr_f(x, low_n);
            default:        y = shl_f(x, rev_n);
        endcase
    end
endmodule

// File: rtl/vsh_core.sv
module vsh_core
    import vsh_pkg::*;
#(
    parameter int LANE_W  = vsh_pkg::LANE_W,
    parameter int SHAMT_W = vsh_pkg::SHAMT_W,
    parameter int LANES   = vsh_pkg::LANES
) (
    input  logic [LANES*LANE_W-1:0] src,
    input  logic [SHAMT_W-1:0]      amt,
    input  logic                    op,
    input  logic                    sat,
    output logic [LANES*LANE_W-1:0] res,
    output logic                    ovf_any
);
    logic [LANES-1:0] lane_ovf;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vsh_lane #(
            .LANE_W (LANE_W),
            .SHAMT_W(SHAMT_W)
        ) u_lane (
            .x  (src[g*LANE_W +: LANE_W]),
            .amt(amt),
            .op (op),
            .sat(sat),
            .y  (res[g*LANE_W +: LANE_W]),
            .ovf(lane_ovf[g])
        );
    end

    assign ovf_any = |lane_ovf;
endmodule

// File: rtl/vsh_dual_shift.sv
module vsh_dual_shift
    import vsh_pkg::*;
#(
    parameter int LANE_W  = vsh_pkg::LANE_W,
    parameter int SHAMT_W = vsh_pkg::SHAMT_W,
    parameter int LANES   = vsh_pkg::LANES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [LANES*LANE_W-1:0] src,
    input  logic [SHAMT_W-1:0]      amt,
    input  logic                    op,
    input  logic                    sat,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] result,
    output logic                    ovf,
    output logic                    sticky
);
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] res;
        logic              ovf;
        logic              sticky;
    } state_t;

    state_t            st_d, st_q;
    logic [WORD_W-1:0] core_res;
    logic              core_ovf;

    vsh_core #(
        .LANE_W (LANE_W),
        .SHAMT_W(SHAMT_W),
        .LANES  (LANES)
    ) u_core (
        .src    (src),
        .amt    (amt),
        .op     (op),
        .sat    (sat),
        .res    (core_res),
        .ovf_any(core_ovf)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res    = core_res;
            st_d.ovf    = core_ovf;
            st_d.sticky = st_q.sticky | core_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;
    assign ovf       = st_q.ovf;
    assign sticky    = st_q.sticky;
endmodule

// File: rtl/vsh_dual_shift_chk.sv
module vsh_dual_shift_chk #(
    parameter int WORD_W  = 32,
    parameter int SHAMT_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] src,
    input logic [SHAMT_W-1:0] amt,
    input logic              op,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              ovf,
    input logic              sticky
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_hold_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && $stable(result) && $stable(ovf));

    assert_zero_amount_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && amt == '0) |=> result == $past(src));

    assert_asr_no_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op && !amt[SHAMT_W-1]) |=> !ovf);

    assert_rev_no_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op && amt[SHAMT_W-1]) |=> !ovf);

    assert_negleft_no_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op && amt[SHAMT_W-1]) |=> !ovf);

    assert_sticky_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sticky |=> sticky);

    assert_ovf_in_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> sticky);

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !ovf && !sticky && result == '0);
endmodule

bind vsh_dual_shift vsh_dual_shift_chk #(
    .WORD_W (LANES * LANE_W),
    .SHAMT_W(SHAMT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .src      (src),
    .amt      (amt),
    .op       (op),
    .out_valid(out_valid),
    .result   (result),
    .ovf      (ovf),
    .sticky   (sticky)
);

// File: tb/sim_vsh_dual_shift.sv
module sim_vsh_dual_shift;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] src;
    logic [4:0]  amt;
    logic        op;
    logic        sat;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf;
    logic        sticky;

    int checks = 0;
    int errors = 0;
    logic sticky_exp = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    vsh_dual_shift u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .amt(amt),
        .op(op), .sat(sat), .out_valid(out_valid), .result(result),
        .ovf(ovf), .sticky(sticky)
    );

    function automatic void ref_lane(input logic [15:0] x, input logic [4:0] a,
                                     input logic o, input logic s,
                                     output logic [15:0] r, output logic v);
        int xi, ai, p, n;
        xi = int'($signed(x));
        ai = int'($signed(a));
        v  = 1'b0;
        if (!o) begin
            if (ai >= 0) begin
                p = xi * (1 << ai);
                if (p > 32767 || p < -32768) begin
                    v = 1'b1;
                    r = s ? (xi < 0 ? 16'h8000 : 16'h7FFF) : p[15:0];
                end else r = p[15:0];
            end else begin
                p = xi >>> (-ai);
                r = p[15:0];
            end
        end else begin
            if (ai >= 0) begin
                p = xi >>> ai;
                r = p[15:0];
            end else begin
                n = 16 - (ai & 15);
                p = int'(x) * (1 << n);
                r = p[15:0];
            end
        end
    endfunction

    function automatic string path_tag(input logic [4:0] a, input logic o,
                                       input logic s, input logic v);
        if (o) return a[4] ? "R8" : "R7";
        if (a[4]) return "R6";
        if (!v) return "R3";
        return s ? "R4" : "R5";
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] w, input logic [4:0] a,
                          input logic o, input logic s);
        logic [15:0] r0, r1;
        logic v0, v1;
        string t;
        ref_lane(w[15:0], a, o, s, r0, v0);
        ref_lane(w[31:16], a, o, s, r1, v1);
        @(negedge clk);
        in_valid = 1'b1; src = w; amt = a; op = o; sat = s;
        @(negedge clk);
        in_valid = 1'b0;
        sticky_exp = sticky_exp | v0 | v1;
        t = path_tag(a, o, s, v0);
        check(t, 32'(result[15:0]), 32'(r0));
        t = path_tag(a, o, s, v1);
        check({"R2 ", t}, 32'(result[31:16]), 32'(r1));
        check("R5 ovf", 32'(ovf), 32'(v0 | v1));
        check("R9 sticky", 32'(sticky), 32'(sticky_exp));
        check("R1 valid", 32'(out_valid), 32'd1);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] corners [6];
        logic [31:0] held;
        corners[0] = 16'h0000; corners[1] = 16'h7FFF; corners[2] = 16'h8000;
        corners[3] = 16'hFFFF; corners[4] = 16'h0001; corners[5] = 16'hC001;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; src = '0; amt = '0; op = 1'b0; sat = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 valid", 32'(out_valid), 32'd0);
        check("R10 result", result, 32'd0);
        check("R10 ovf", 32'(ovf), 32'd0);
        check("R10 sticky", 32'(sticky), 32'd0);
        rst_n = 1'b1;

        // sticky must stay clear through non-overflowing work
        run_op(32'h1234_8000, 5'd0, 1'b0, 1'b0);
        run_op(32'h8000_7FFF, 5'd16, 1'b1, 1'b0);
        run_op(32'h8000_7FFF, 5'd16, 1'b0, 1'b0);

        for (int a = 0; a < 32; a++)
            for (int o = 0; o < 2; o++)
                for (int s = 0; s < 2; s++)
                    for (int k = 0; k < 6; k++)
                        run_op({corners[(k + 3) % 6], corners[k]}, 5'(a), 1'(o), 1'(s));

        // R1: result and flag hold while in_valid is low
        held = result;
        @(negedge clk);
        src = ~src; amt = amt + 5'd1;
        @(negedge clk);
        check("R1 hold result", result, held);
        check("R1 drop valid", 32'(out_valid), 32'd0);

        for (int i = 0; i < 400; i++)
            run_op($urandom(), 5'($urandom()), 1'($urandom()), 1'($urandom()));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule